// File: doc/BRIEF.md
# Receiver Output Enable Sequencer

This block sits between the deserializer of a dual-channel video link receiver and its parallel pixel pins. It keeps the even and odd output buses at zero until the recovered clock has been seen for a programmable number of cycles. The wait is a short one or a long one, and a configuration bit picks which. Once the wait ends, it passes pixel data through a register stage. A separate disable bit for each sub-lane can still hold that sub-lane at zero.

If the clock-detect indication drops, or power-down is asserted, the outputs shut off on the next edge and the wait starts again from zero. The block also registers the output strobe-edge select and a normalised setup/hold shift code. The output timing stage downstream uses both. All control inputs are static configuration fields that a register interface writes.

Top module: `rx_out_gate`

## Requirements
- R1: After reset `even_data_o`, `odd_data_o`, `out_valid_o`, `strobe_fall_o` and `shift_sel_o` are all zero.
- R2: With `wait_long_i` = 0, `out_valid_o` rises on the SHORT_WAIT-th consecutive rising edge at which `clk_detect_i` = 1 and `pwr_down_i` = 0, counting from the first such edge.
- R3: With `wait_long_i` = 1, the same release happens on the LONG_WAIT-th such edge.
- R4: `wait_long_i` is sampled on the first counting edge of a lock sequence. A change while the count is running has no effect until the next sequence.
- R5: An edge at which `clk_detect_i` = 0 clears the count. `out_valid_o` and both data buses are 0 after that edge, and a fresh full wait is then needed.
- R6: `pwr_down_i` = 1 at an edge acts exactly like a loss of clock detect (R5).
- R7: `chan_off_i` bit i (i < LANES) disables even sub-lane i, which is bits [i*LANE_W +: LANE_W]. Bit LANES+i disables odd sub-lane i. A disabled sub-lane outputs zeros, and enabled sub-lanes are unaffected. 0 means enabled.
- R8: While released, each data output equals the corresponding input sampled at the previous rising edge. While not released, both data buses are zero.
- R9: `strobe_fall_o` equals `edge_fall_i` sampled at the previous edge (1 = launch on falling edge, 0 = rising).
- R10: `shift_sel_o` is `shift_code_i` sampled at the previous edge, with code 11 mapped to 00. Codes: 00 balanced, 01 setup +1 UI / hold -1 UI, 10 setup -1 UI / hold +1 UI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_detect_i | input | 1 | Recovered clock present indication |
| pwr_down_i | input | 1 | Power-down request |
| wait_long_i | input | 1 | 0 = short wait, 1 = long wait |
| edge_fall_i | input | 1 | Output strobe edge select |
| shift_code_i | input | 2 | Setup/hold shift code |
| chan_off_i | input | 2*LANES | Per sub-lane disable, even lanes low |
| even_data_i | input | LANES*LANE_W | Deserialized even-pixel data |
| odd_data_i | input | LANES*LANE_W | Deserialized odd-pixel data |
| even_data_o | output | LANES*LANE_W | Gated even-pixel bus |
| odd_data_o | output | LANES*LANE_W | Gated odd-pixel bus |
| out_valid_o | output | 1 | Outputs released |
| strobe_fall_o | output | 1 | Registered strobe edge select |
| shift_sel_o | output | 2 | Normalised setup/hold shift code |

## Verification
The bench builds the block with SHORT_WAIT = 8, LONG_WAIT = 16, LANES = 2 and LANE_W = 4. With these values both wait lengths run to completion many times in a short run. The bench can therefore reach mid-count changes of the length bit, repeated relocks after a dropped detect or a power-down pulse, and every combination of lane disables. The default 1024/2048 widths change only the counter size, not the sequencing.

// File: rtl/rxg_pkg.sv
package rxg_pkg;

    typedef enum logic [1:0] {
        SH_BAL      = 2'b00,
        SH_SETUP_UP = 2'b01,
        SH_HOLD_UP  = 2'b10
    } shift_e;

    function automatic logic [1:0] norm_shift(input logic [1:0] code);
        logic [1:0] r;
        case (code)
            2'b01:   r = SH_SETUP_UP;
            2'b10:   r = SH_HOLD_UP;
            default: r = SH_BAL;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rxg_wait_ctr.sv
module rxg_wait_ctr #(
    parameter int SHORT_WAIT = 1024,
    parameter int LONG_WAIT  = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic alive_i,
    input  logic wait_long_i,
    output logic ready_o,
    output logic ready_next_o
);
    localparam int CW = $clog2(LONG_WAIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lim_long;
        logic          ready;
    } st_s;

    st_s st_d, st_q;

    always_comb begin
        logic          eff_long;
        logic [CW-1:0] last;
        st_d     = st_q;
        eff_long = (st_q.cnt == '0) ? wait_long_i : st_q.lim_long;
        last     = eff_long ? CW'(LONG_WAIT - 1) : CW'(SHORT_WAIT - 1);
        st_d.lim_long = eff_long;
        if (!alive_i) begin
            st_d.cnt   = '0;
            st_d.ready = 1'b0;
        end else if (!st_q.ready) begin
            if (st_q.cnt == last) begin
                st_d.cnt   = '0;
                st_d.ready = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o      = st_q.ready;
    assign ready_next_o = st_d.ready;

    // R5
    loss_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !alive_i |=> (!st_q.ready && st_q.cnt == '0));

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < CW'(LONG_WAIT));

    // R2
    release_needs_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ready) |-> $past(alive_i));

    // R4
    lim_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0 && alive_i && !st_q.ready) |=> $stable(st_q.lim_long));
endmodule

// File: rtl/rxg_lane_gate.sv
module rxg_lane_gate #(
    parameter int LANE_W = 10
) (
    input  logic [LANE_W-1:0] din_i,
    input  logic              en_i,
    input  logic              off_i,
    output logic [LANE_W-1:0] dout_o
);
    always_comb begin
        dout_o = (en_i && !off_i) ? din_i : '0;
    end
endmodule

// File: rtl/rx_out_gate.sv
module rx_out_gate #(
    parameter int SHORT_WAIT = 1024,
    parameter int LONG_WAIT  = 2048,
    parameter int LANES      = 5,
    parameter int LANE_W     = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clk_detect_i,
    input  logic                      pwr_down_i,
    input  logic                      wait_long_i,
    input  logic                      edge_fall_i,
    input  logic [1:0]                shift_code_i,
    input  logic [2*LANES-1:0]        chan_off_i,
    input  logic [LANES*LANE_W-1:0]   even_data_i,
    input  logic [LANES*LANE_W-1:0]   odd_data_i,
    output logic [LANES*LANE_W-1:0]   even_data_o,
    output logic [LANES*LANE_W-1:0]   odd_data_o,
    output logic                      out_valid_o,
    output logic                      strobe_fall_o,
    output logic [1:0]                shift_sel_o
);
    import rxg_pkg::*;

    localparam int BUS_W = LANES * LANE_W;

    typedef struct packed {
        logic [BUS_W-1:0] even;
        logic [BUS_W-1:0] odd;
        logic             strobe_fall;
        logic [1:0]       shift;
    } out_s;

    out_s out_d, out_q;

    logic             alive;
    logic             ready_q;
    logic             ready_d;
    logic [BUS_W-1:0] even_g;
    logic [BUS_W-1:0] odd_g;

    assign alive = clk_detect_i && !pwr_down_i;

    rxg_wait_ctr #(
        .SHORT_WAIT(SHORT_WAIT),
        .LONG_WAIT (LONG_WAIT)
    ) u_wait (
        .clk         (clk),
        .rst_n       (rst_n),
        .alive_i     (alive),
        .wait_long_i (wait_long_i),
        .ready_o     (ready_q),
        .ready_next_o(ready_d)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        rxg_lane_gate #(.LANE_W(LANE_W)) u_even (
            .din_i (even_data_i[i*LANE_W +: LANE_W]),
            .en_i  (ready_d),
            .off_i (chan_off_i[i]),
            .dout_o(even_g[i*LANE_W +: LANE_W])
        );
        rxg_lane_gate #(.LANE_W(LANE_W)) u_odd (
            .din_i (odd_data_i[i*LANE_W +: LANE_W]),
            .en_i  (ready_d),
            .off_i (chan_off_i[LANES+i]),
            .dout_o(odd_g[i*LANE_W +: LANE_W])
        );

        // R7
        even_lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chan_off_i[i] |=> even_data_o[i*LANE_W +: LANE_W] == '0);
        // R7
        odd_lane_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            chan_off_i[LANES+i] |=> odd_data_o[i*LANE_W +: LANE_W] == '0);
    end

    always_comb begin
        out_d             = out_q;
        out_d.even        = even_g;
        out_d.odd         = odd_g;
        out_d.strobe_fall = edge_fall_i;
        out_d.shift       = norm_shift(shift_code_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign even_data_o   = out_q.even;
    assign odd_data_o    = out_q.odd;
    assign out_valid_o   = ready_q;
    assign strobe_fall_o = out_q.strobe_fall;
    assign shift_sel_o   = out_q.shift;

    // R6
    pwr_down_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> (!out_valid_o && even_data_o == '0 && odd_data_o == '0));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (even_data_o == '0 && odd_data_o == '0));

    // R10
    no_code11_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_sel_o != 2'b11);

    // R9
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> strobe_fall_o == $past(edge_fall_i));
endmodule

// File: tb/tb_rx_out_gate.sv
module tb_rx_out_gate;
    localparam int SW = 8;
    localparam int LW = 16;
    localparam int LN = 2;
    localparam int LWD = 4;
    localparam int BW = LN * LWD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det = 1'b0, pd = 1'b0, wl = 1'b0, ef = 1'b0;
    logic [1:0] sc = 2'b00;
    logic [2*LN-1:0] off = '0;
    logic [BW-1:0] ein = '0, oin = '0;
    logic [BW-1:0] eout, oout;
    logic vout, sfout;
    logic [1:0] shout;

    int checks = 0;
    int errors = 0;
    string req = "R1";

    always #4 clk = ~clk;

    rx_out_gate #(.SHORT_WAIT(SW), .LONG_WAIT(LW), .LANES(LN), .LANE_W(LWD)) dut (
        .clk(clk), .rst_n(rst_n), .clk_detect_i(det), .pwr_down_i(pd),
        .wait_long_i(wl), .edge_fall_i(ef), .shift_code_i(sc), .chan_off_i(off),
        .even_data_i(ein), .odd_data_i(oin), .even_data_o(eout), .odd_data_o(oout),
        .out_valid_o(vout), .strobe_fall_o(sfout), .shift_sel_o(shout));

    // behavioural reference
    int m_cnt = 0;
    bit m_lim = 0;
    bit m_rdy = 0;
    logic [BW-1:0] x_e = '0, x_o = '0;
    logic x_sf = 0;
    logic [1:0] x_sh = 0;

    function automatic logic [BW-1:0] mask(input logic [BW-1:0] d, input logic [LN-1:0] o);
        logic [BW-1:0] r = d;
        for (int i = 0; i < LN; i++)
            if (o[i]) r[i*LWD +: LWD] = '0;
        return r;
    endfunction

    always @(posedge clk) begin
        bit eff, nr;
        int n, nc;
        if (!rst_n) begin
            m_cnt <= 0; m_lim <= 0; m_rdy <= 0;
            x_e <= '0; x_o <= '0; x_sf <= 0; x_sh <= 0;
        end else begin
            eff = (m_cnt == 0) ? wl : m_lim;
            n = eff ? LW : SW;
            nr = m_rdy; nc = m_cnt;
            if (!det || pd) begin nr = 0; nc = 0; end
            else if (!m_rdy) begin
                if (m_cnt + 1 == n) begin nr = 1; nc = 0; end
                else nc = m_cnt + 1;
            end
            m_cnt <= nc; m_lim <= eff; m_rdy <= nr;
            x_e <= nr ? mask(ein, off[LN-1:0]) : '0;
            x_o <= nr ? mask(oin, off[2*LN-1:LN]) : '0;
            x_sf <= ef;
            x_sh <= (sc == 2'b11) ? 2'b00 : sc;
        end
    end

    task automatic cmp(input string what, input logic [BW-1:0] a, input logic [BW-1:0] e);
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, a, e);
        end
    endtask

    always @(negedge clk) if (rst_n || req == "R1") begin
        cmp("valid", BW'(vout), BW'(m_rdy));
        cmp("even", eout, x_e);
        cmp("odd", oout, x_o);
        cmp("strobe", BW'(sfout), BW'(x_sf));
        cmp("shift", BW'(shout), BW'(x_sh));
    end

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #1;
            ein = BW'($urandom); oin = BW'($urandom);
        end
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        step(3);
        req = "R1"; step(1);
        @(posedge clk); #1 rst_n = 1'b1;
        req = "R2"; det = 1; wl = 0; step(SW + 4);
        req = "R8"; step(5);
        req = "R7"; off = 4'b0001; step(3); off = 4'b1010; step(3); off = 4'b1111; step(2); off = 0; step(2);
        req = "R5"; det = 0; step(1); det = 1; step(3); det = 0; step(2); det = 1; step(SW + 3);
        req = "R3"; det = 0; wl = 1; step(2); det = 1; step(LW + 3);
        req = "R4"; det = 0; wl = 0; step(1); det = 1; step(3); wl = 1; step(SW + 2);
        det = 0; step(1); det = 1; step(SW + 2); wl = 0; step(LW);
        req = "R6"; pd = 1; step(2); pd = 0; step(3); pd = 1; step(1); pd = 0; step(SW + 3);
        req = "R9"; ef = 1; step(2); ef = 0; step(1); ef = 1; step(2);
        req = "R10"; for (int c = 0; c < 4; c++) begin sc = 2'(c); step(2); end
        step(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule